// File: doc/BRIEF.md
# First-Hit Address Latch

This block watches a bank of detector channels and reports the first one to fire. Each channel supplies two single-cycle strobes: one for a threshold crossing and one for a found peak. A mode input chooses which of the two kinds of strobe counts as an event. On the first clock in which any selected strobe is high, the block raises a flag and presents the index of the firing channel on an address output. If several channels fire in that same cycle, the lowest index wins.

After it captures, the block ignores every strobe for a fixed hold window, counted in clock cycles and set by a parameter. The window stands for a 40 ns interval: 4 cycles at 100 MHz or 16 cycles at 400 MHz. When the window expires the flag drops and the block re-arms itself. No external clear is needed. A synchronous reset returns the block to its armed, idle state.

Internally a two-state machine (ARMED, HELD) drives the outputs. It moves ARMED to HELD on capture (any selected strobe high while armed) and HELD to ARMED on expiry (the hold counter reaches its last cycle). All other cases keep the current state.

Top module: `fha_first_hit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next cycle shows `first_flag` = 0 and `first_addr` = 0. This holds even when reset arrives in the middle of a hold window.
- R2: With `src_peak` = 0, a high bit of `thr_strb` is an event and `peak_strb` has no effect.
- R3: With `src_peak` = 1, a high bit of `peak_strb` is an event and `thr_strb` has no effect.
- R4: When armed and an event is present in a cycle, `first_flag` is 1 in the next cycle. `first_addr` then equals the channel index, where bit i of a strobe vector is channel i.
- R5: When several channels have events in the same capture cycle, `first_addr` is the lowest index among them.
- R6: After a capture, `first_flag` stays high for exactly `HOLD_CYC` consecutive cycles and then falls without any outside action.
- R7: While `first_flag` is high, `first_addr` does not change and all strobes are ignored.
- R8: Strobes present in the last held cycle are ignored. After the flag falls, the block is armed for at least one cycle, and a strobe present in that cycle is captured, so the flag rises again in the cycle after.
- R9: Whenever `first_flag` is 0, `first_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_peak | input | 1 | Event source: 0 threshold strobes, 1 peak strobes |
| thr_strb | input | NUM_CH | Threshold-crossing strobe per channel |
| peak_strb | input | NUM_CH | Peak-found strobe per channel |
| first_flag | output | 1 | High for the hold window after a capture |
| first_addr | output | $clog2(NUM_CH) | Index of the captured channel, 0 when idle |

## Verification
The assertions check on every cycle that an armed block captures exactly when a selected strobe is present. They also check that the address is zero whenever the flag is low and frozen while it is high, that the flag never stays high longer than the window, and that it always falls after exactly the window. Only the bench scenarios can show which channel index is reported: the lowest-index choice among simultaneous strobes, both edge channels, the unselected source being ignored in each mode, the exact one-cycle re-arm gap under a strobe that never goes away, and reset cutting a window short.

// File: rtl/fha_pkg.sv
`timescale 1ns/1ps
package fha_pkg;

    typedef enum logic {
        FHA_ARMED = 1'b0,
        FHA_HELD  = 1'b1
    } fha_state_e;

endpackage

// File: rtl/fha_src_mux.sv
`timescale 1ns/1ps
// Picks the strobe vector that counts as an event.
module fha_src_mux #(
    parameter int NUM_CH = 64
) (
    input  logic              use_peak,
    input  logic [NUM_CH-1:0] thr_vec,
    input  logic [NUM_CH-1:0] peak_vec,
    output logic [NUM_CH-1:0] evt_vec
);

    always_comb begin
        evt_vec = use_peak ? peak_vec : thr_vec;
    end

endmodule

// File: rtl/fha_prio_enc.sv
`timescale 1ns/1ps
// Lowest-index-wins priority encoder.
module fha_prio_enc #(
    parameter int NUM_CH = 64,
    localparam int ADDR_W = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] req,
    output logic              any,
    output logic [ADDR_W-1:0] idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = i[ADDR_W-1:0];
            end
        end
    end

endmodule

// File: rtl/fha_hold_timer.sv
`timescale 1ns/1ps
// Down-counter for the hold window; expire is high in the last held cycle.
module fha_hold_timer #(
    parameter int HOLD_CYC = 4,
    localparam int CNT_W = $clog2(HOLD_CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic active,
    output logic expire
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_W'(HOLD_CYC - 1);
        end else if (active && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        expire = active && (cnt_q == '0);
    end

endmodule

// File: rtl/fha_first_hit.sv
`timescale 1ns/1ps
module fha_first_hit
    import fha_pkg::*;
#(
    parameter int NUM_CH   = 64,
    parameter int HOLD_CYC = 4,
    localparam int ADDR_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              src_peak,
    input  logic [NUM_CH-1:0] thr_strb,
    input  logic [NUM_CH-1:0] peak_strb,
    output logic              first_flag,
    output logic [ADDR_W-1:0] first_addr
);

    fha_state_e        state_q, state_d;
    logic [NUM_CH-1:0] evt_vec;
    logic              evt_any;
    logic [ADDR_W-1:0] evt_idx;
    logic              capture;
    logic              expire;
    logic              flag_q;
    logic [ADDR_W-1:0] addr_q;

    fha_src_mux #(.NUM_CH(NUM_CH)) u_mux (
        .use_peak (src_peak),
        .thr_vec  (thr_strb),
        .peak_vec (peak_strb),
        .evt_vec  (evt_vec)
    );

    fha_prio_enc #(.NUM_CH(NUM_CH)) u_enc (
        .req (evt_vec),
        .any (evt_any),
        .idx (evt_idx)
    );

    fha_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (capture),
        .active (state_q == FHA_HELD),
        .expire (expire)
    );

    always_comb begin
        capture = (state_q == FHA_ARMED) && evt_any;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FHA_ARMED: if (evt_any) state_d = FHA_HELD;
            FHA_HELD:  if (expire)  state_d = FHA_ARMED;
            default:   state_d = FHA_ARMED;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FHA_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            addr_q <= '0;
        end else begin
            unique case (state_q)
                FHA_ARMED: begin
                    if (evt_any) begin
                        flag_q <= 1'b1;
                        addr_q <= evt_idx;
                    end else begin
                        flag_q <= 1'b0;
                        addr_q <= '0;
                    end
                end
                FHA_HELD: begin
                    if (expire) begin
                        flag_q <= 1'b0;
                        addr_q <= '0;
                    end
                end
                default: begin
                    flag_q <= 1'b0;
                    addr_q <= '0;
                end
            endcase
        end
    end

    assign first_flag = flag_q;
    assign first_addr = addr_q;

endmodule

// File: rtl/fha_first_hit_chk.sv
`timescale 1ns/1ps
module fha_first_hit_chk #(
    parameter int NUM_CH   = 64,
    parameter int HOLD_CYC = 4,
    localparam int ADDR_W  = $clog2(NUM_CH),
    localparam int RUN_W   = $clog2(HOLD_CYC + 2)
) (
    input logic              clk,
    input logic              rst,
    input logic              src_peak,
    input logic [NUM_CH-1:0] thr_strb,
    input logic [NUM_CH-1:0] peak_strb,
    input logic              first_flag,
    input logic [ADDR_W-1:0] first_addr
);

    logic             sel_any;
    logic [RUN_W-1:0] run_q;

    assign sel_any = src_peak ? (|peak_strb) : (|thr_strb);

    // Number of consecutive high-flag cycles seen before the current one.
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (first_flag) begin
            if (run_q != RUN_W'(HOLD_CYC + 1)) run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!first_flag && first_addr == '0));

    a_r4_capture: assert property (@(posedge clk) disable iff (rst)
        (!first_flag && sel_any) |=> first_flag);

    // R2 and R3: no selected strobe while armed means no capture
    a_r2_r3_no_spurious: assert property (@(posedge clk) disable iff (rst)
        (!first_flag && !sel_any) |=> !first_flag);

    a_r6_max_len: assert property (@(posedge clk) disable iff (rst)
        first_flag |-> (run_q < RUN_W'(HOLD_CYC)));

    a_r6_full_len: assert property (@(posedge clk) disable iff (rst)
        (first_flag && run_q == RUN_W'(HOLD_CYC - 1)) |=> !first_flag);

    a_r7_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (first_flag && run_q != '0) |-> $stable(first_addr));

    a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !first_flag |-> (first_addr == '0));

endmodule

bind fha_first_hit fha_first_hit_chk #(
    .NUM_CH   (NUM_CH),
    .HOLD_CYC (HOLD_CYC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .src_peak   (src_peak),
    .thr_strb   (thr_strb),
    .peak_strb  (peak_strb),
    .first_flag (first_flag),
    .first_addr (first_addr)
);

// File: tb/fha_first_hit_tb.sv
`timescale 1ns/1ps
module fha_first_hit_tb;

    localparam int CLK_NS = 10;
    localparam int NCH    = 64;
    localparam int HOLD   = 4;

    typedef struct {
        logic [5:0] addr;
        string      tag;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           mode = 1'b0;
    logic [NCH-1:0] thr = '0;
    logic [NCH-1:0] pk = '0;
    logic           flag;
    logic [5:0]     addr;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    int         high_run = 0;
    int         low_run = 0;
    int         last_gap = 0;
    logic       prev_flag = 1'b0;
    logic [5:0] held_addr = '0;

    always #(CLK_NS/2) clk = ~clk;

    fha_first_hit #(.NUM_CH(NCH), .HOLD_CYC(HOLD)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .src_peak   (mode),
        .thr_strb   (thr),
        .peak_strb  (pk),
        .first_flag (flag),
        .first_addr (addr)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic apply(input logic m, input logic [NCH-1:0] t, input logic [NCH-1:0] p);
        @(negedge clk); #1;
        mode = m; thr = t; pk = p;
    endtask

    task automatic release_after(input int n);
        repeat (n) @(negedge clk);
        #1; thr = '0; pk = '0;
    endtask

    task automatic push(input logic [5:0] a, input string tag);
        exp_t e;
        e.addr = a; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst) begin
            prev_flag = 1'b0; high_run = 0; low_run = 0;
        end else begin
            if (flag && !prev_flag) begin
                if (q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R2 R3 unexpected capture actual addr %0d expected none", addr);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(e.tag, addr, e.addr);
                end
                held_addr = addr;
                last_gap = low_run;
                low_run = 0;
                high_run = 1;
            end else if (flag) begin
                chk("R7 address held", addr, held_addr);
                high_run++;
            end
            if (!flag && prev_flag) begin
                chk("R6 flag length", high_run, HOLD);
                high_run = 0;
            end
            if (!flag) begin
                chk("R9 idle address", addr, 0);
                low_run++;
            end
            prev_flag = flag;
        end
    end

    initial begin
        #(CLK_NS * 200000);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [NCH-1:0] v;
        idle(3);
        chk("R1 reset flag", flag, 0);
        chk("R1 reset addr", addr, 0);
        @(negedge clk); #1; rst = 1'b0;
        idle(2);

        // R2, R4: threshold source, channel 5
        push(6'd5, "R4 R2 threshold capture ch5");
        apply(1'b0, NCH'(1) << 5, '0);
        release_after(1);
        idle(HOLD + 2);

        // R2: peak strobe ignored in threshold mode
        apply(1'b0, '0, NCH'(1) << 9);
        release_after(1);
        idle(2);
        chk("R2 peak ignored", flag, 0);
        idle(HOLD);

        // R3: peak source, top channel
        push(6'd63, "R3 peak capture ch63");
        apply(1'b1, '0, NCH'(1) << 63);
        release_after(1);
        idle(HOLD + 2);

        // R3: threshold strobe ignored in peak mode
        apply(1'b1, NCH'(1) << 17, '0);
        release_after(1);
        idle(2);
        chk("R3 threshold ignored", flag, 0);
        idle(HOLD);

        // R5: several channels at once
        v = '0; v[40] = 1'b1; v[12] = 1'b1; v[33] = 1'b1;
        push(6'd12, "R5 lowest of 12 33 40");
        apply(1'b0, v, '0);
        release_after(1);
        idle(HOLD + 2);

        push(6'd0, "R5 all channels give 0");
        apply(1'b0, '1, '1);
        release_after(1);
        idle(HOLD + 2);

        // R7: strobes during hold are ignored
        push(6'd7, "R7 capture ch7");
        apply(1'b0, NCH'(1) << 7, '0);
        release_after(1);
        #0; thr = NCH'(1) << 1;
        release_after(2);
        idle(1);
        chk("R7 addr during hold", addr, 7);
        idle(HOLD + 2);

        // R8: strobe that stays on is re-captured after one armed cycle
        push(6'd3, "R8 first capture ch3");
        push(6'd3, "R8 recapture ch3");
        apply(1'b0, NCH'(1) << 3, '0);
        release_after(HOLD + 2);
        idle(2);
        chk("R8 re-arm gap", last_gap, 1);
        idle(HOLD + 2);

        // R1: reset cuts a hold window short
        push(6'd20, "R4 capture ch20");
        apply(1'b0, NCH'(1) << 20, '0);
        release_after(1);
        idle(1);
        #1; rst = 1'b1;
        idle(2);
        chk("R1 mid-hold reset flag", flag, 0);
        chk("R1 mid-hold reset addr", addr, 0);
        #1; rst = 1'b0;
        idle(2);

        // R6: next capture after reset still has a full window
        push(6'd44, "R6 capture ch44");
        apply(1'b0, NCH'(1) << 44, '0);
        release_after(1);
        idle(HOLD + 3);

        chk("R4 all expected captures seen", q.size(), 0);
        finish_run();
    end

endmodule